// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects interrupt requests from a two-channel serial controller and turns them into a single interrupt request toward a CPU that services devices along a priority daisy chain. Each channel raises four kinds of event: transmit, external/status, receive and error. Every one of the eight sources keeps a pending flag and an in-service flag. A per-source set pulse marks it pending, and a per-source clear pulse withdraws it.

When the CPU acknowledges, the block moves the most urgent pending source into service. It also drives an 8-bit vector made from a programmable base plus twice that source's index. A return strobe ends the most urgent service in progress. A source in service masks its own requests and all requests below it, but requests above it still get through, so service can nest. A daisy enable input and output let the block sit inside a longer chain of devices.

Top module: `irq_vec_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every pending and in-service flag, so afterwards irq_o is 0 and ieo_o follows ien_i.
- R2: A set pulse on source k makes it pending from the next cycle, and irq_o rises if ien_i is 1 and nothing of equal or higher priority is in service.
- R3: Source index is channel*4 + type, with channel B = 0, channel A = 1, and type transmit = 0, status = 1, receive = 2, error = 3. From most to least urgent, the sources are 6, 4, 5, 7, 2, 0, 1, 3.
- R4: vec_o equals base_vec + 2*index of the most urgent pending source, modulo 256, and equals base_vec unchanged when nothing is pending. The value on vec_o during an acknowledge cycle is the vector returned.
- R5: An acknowledge clears the pending flag of the most urgent pending source and sets its in-service flag. In-service state does not limit which source is chosen.
- R6: irq_o is the OR of pending flags taken in priority order up to, and not including, the first source that is in service.
- R7: A return strobe clears only the in-service flag of the most urgent in-service source.
- R8: A clear pulse removes the source's pending flag and leaves its in-service flag unchanged.
- R9: With ien_i low, irq_o is 0. ieo_o is 1 only when ien_i is 1 and no source is in service.
- R10: When set and clear reach the same source in the same cycle, the source becomes pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_i | input | 8 | Per-source set pulses, bit k for source k |
| clr_i | input | 8 | Per-source clear pulses, bit k for source k |
| base_vec | input | 8 | Base interrupt vector |
| ien_i | input | 1 | Daisy enable from the upstream device |
| ack_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| reti_i | input | 1 | Return-from-interrupt strobe, one cycle |
| irq_o | output | 1 | Interrupt request to the CPU |
| ieo_o | output | 1 | Daisy enable to the downstream device |
| vec_o | output | 8 | Vector of the most urgent pending source |

## Verification
The bench builds the block with its defaults: two channels, which gives eight sources, and an 8-bit vector. All eight priority ranks can therefore be walked in one acknowledge sequence. With an 8-bit vector, a base near the top of the range makes the base-plus-offset sum wrap, which the bench checks. Nested service two levels deep is also reachable, with a lower source in service while a higher one is acknowledged and returned.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  localparam int TYPES_PER_CH = 4;

  // Maps a priority rank (0 = most urgent) to a source index.
  // The highest channel comes first; within a channel the type order is receive, transmit, status, error.
  function automatic int rank_to_src(int rank, int num_ch);
    int ch;
    int slot;
    int typ;
    ch   = num_ch - 1 - (rank / TYPES_PER_CH);
    slot = rank % TYPES_PER_CH;
    case (slot)
      0:       typ = 2;
      1:       typ = 0;
      2:       typ = 1;
      default: typ = 3;
    endcase
    return ch * TYPES_PER_CH + typ;
  endfunction

  // Vector arithmetic: base plus twice the source index (caller truncates).
  function automatic logic [31:0] vec_add(logic [31:0] base, logic [31:0] idx);
    return base + (idx << 1);
  endfunction

endpackage

// File: rtl/ivc_prio_scan.sv
module ivc_prio_scan #(
  parameter int NUM_CH = 2,
  parameter int N      = 4 * NUM_CH,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     insv,
  output logic             req_raw,
  output logic             any_pend,
  output logic [N-1:0]     ack_oh,
  output logic [N-1:0]     reti_oh,
  output logic [IDX_W-1:0] ack_idx
);

  logic [N-1:0] pend_r;
  logic [N-1:0] insv_r;
  logic [N:0]   pend_seen;
  logic [N:0]   insv_seen;
  logic [N-1:0] live_r;

  assign pend_seen[0] = 1'b0;
  assign insv_seen[0] = 1'b0;

  for (genvar r = 0; r < N; r++) begin : g_rank
    localparam int SRC = ivc_pkg::rank_to_src(r, NUM_CH);
    assign pend_r[r]      = pend[SRC];
    assign insv_r[r]      = insv[SRC];
    assign pend_seen[r+1] = pend_seen[r] | pend_r[r];
    assign insv_seen[r+1] = insv_seen[r] | insv_r[r];
    // A source counts only if nothing at or above it is in service.
    assign live_r[r]      = pend_r[r] & ~insv_seen[r+1];
    assign ack_oh[SRC]    = pend_r[r] & ~pend_seen[r];
    assign reti_oh[SRC]   = insv_r[r] & ~insv_seen[r];
  end

  assign req_raw  = |live_r;
  assign any_pend = pend_seen[N];

  always_comb begin
    ack_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ack_oh[i]) ack_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         ack_fire,
  input  logic         reti_fire,
  input  logic [N-1:0] ack_oh,
  input  logic [N-1:0] reti_oh,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] insv_q
);

  for (genvar k = 0; k < N; k++) begin : g_flag
    logic pend_d;
    logic insv_d;
    // A set pulse wins over a clear pulse or an acknowledge in the same cycle.
    assign pend_d = set_i[k] | (pend_q[k] & ~clr_i[k] & ~(ack_fire & ack_oh[k]));
    assign insv_d = (ack_fire & ack_oh[k]) | (insv_q[k] & ~(reti_fire & reti_oh[k]));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[k] <= 1'b0;
        insv_q[k] <= 1'b0;
      end else begin
        pend_q[k] <= pend_d;
        insv_q[k] <= insv_d;
      end
    end
  end

endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter #(
  parameter int NUM_CH = 2,
  parameter int VEC_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4*NUM_CH-1:0]   set_i,
  input  logic [4*NUM_CH-1:0]   clr_i,
  input  logic [VEC_W-1:0]      base_vec,
  input  logic                  ien_i,
  input  logic                  ack_i,
  input  logic                  reti_i,
  output logic                  irq_o,
  output logic                  ieo_o,
  output logic [VEC_W-1:0]      vec_o
);

  localparam int N     = 4 * NUM_CH;
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     pend_q;
  logic [N-1:0]     insv_q;
  logic [N-1:0]     ack_oh;
  logic [N-1:0]     reti_oh;
  logic [IDX_W-1:0] ack_idx;
  logic             req_raw;
  logic             any_pend;
  logic             ack_fire;
  logic             reti_fire;

  assign ack_fire  = ack_i & any_pend;
  assign reti_fire = reti_i;

  ivc_prio_scan #(.NUM_CH(NUM_CH), .N(N), .IDX_W(IDX_W)) u_scan (
    .pend     (pend_q),
    .insv     (insv_q),
    .req_raw  (req_raw),
    .any_pend (any_pend),
    .ack_oh   (ack_oh),
    .reti_oh  (reti_oh),
    .ack_idx  (ack_idx)
  );

  ivc_flag_bank #(.N(N)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .ack_fire  (ack_fire),
    .reti_fire (reti_fire),
    .ack_oh    (ack_oh),
    .reti_oh   (reti_oh),
    .pend_q    (pend_q),
    .insv_q    (insv_q)
  );

  assign irq_o = ien_i & req_raw;
  assign ieo_o = ien_i & ~(|insv_q);
  assign vec_o = any_pend ? VEC_W'(ivc_pkg::vec_add(32'(base_vec), 32'(ack_idx))) : base_vec;

endmodule

// File: rtl/irq_vec_arbiter_chk.sv
module irq_vec_arbiter_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] set_i,
  input logic [N-1:0] clr_i,
  input logic         ien_i,
  input logic         ack_i,
  input logic         reti_i,
  input logic         irq_o,
  input logic         ieo_o,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] insv_q,
  input logic [N-1:0] ack_oh,
  input logic         any_pend
);

  p_set_pend_r2: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_oh));

  p_ack_insv_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_i && any_pend) |=> ((insv_q & $past(ack_oh)) != '0));

  p_ack_unpend_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_i && any_pend) |=> ((pend_q & $past(ack_oh & ~set_i)) == '0));

  p_block_ieo_r6: assert property (@(posedge clk) disable iff (rst)
    (|insv_q) |-> !ieo_o);

  p_reti_single_r7: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !ack_i && (|insv_q)) |=> ($countones(insv_q) + 1 == $countones($past(insv_q))));

  p_clr_pend_r8: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

  p_keep_insv_r8: assert property (@(posedge clk) disable iff (rst)
    !reti_i |=> ((insv_q & $past(insv_q)) == $past(insv_q)));

  p_ien_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !ien_i |-> (!irq_o && !ieo_o));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & clr_i)) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

endmodule

bind irq_vec_arbiter irq_vec_arbiter_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .set_i    (set_i),
  .clr_i    (clr_i),
  .ien_i    (ien_i),
  .ack_i    (ack_i),
  .reti_i   (reti_i),
  .irq_o    (irq_o),
  .ieo_o    (ieo_o),
  .pend_q   (pend_q),
  .insv_q   (insv_q),
  .ack_oh   (ack_oh),
  .any_pend (any_pend)
);

// File: tb/irq_vec_arbiter_test.sv
module irq_vec_arbiter_test;

  localparam int CLK_HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] set_i = '0;
  logic [7:0] clr_i = '0;
  logic [7:0] base_vec = 8'h40;
  logic       ien_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       irq_o;
  logic       ieo_o;
  logic [7:0] vec_o;

  int total = 0;
  int bad = 0;
  int prio [8] = '{6, 4, 5, 7, 2, 0, 1, 3};

  always #CLK_HALF clk = ~clk;

  irq_vec_arbiter uut (
    .clk(clk), .rst(rst), .set_i(set_i), .clr_i(clr_i), .base_vec(base_vec),
    .ien_i(ien_i), .ack_i(ack_i), .reti_i(reti_i),
    .irq_o(irq_o), .ieo_o(ieo_o), .vec_o(vec_o)
  );

  function automatic logic [7:0] exp_vec(logic [7:0] b, int idx);
    return b + 8'(idx * 2);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string req, input string what);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic do_set(input logic [7:0] m);
    set_i = m; @(negedge clk); set_i = '0;
  endtask

  task automatic do_clr(input logic [7:0] m);
    clr_i = m; @(negedge clk); clr_i = '0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    ack_i = 1'b1; #1 v = vec_o; @(negedge clk); ack_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; @(negedge clk); reti_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq_o, 0, "R1", "irq after reset");
    chk(ieo_o, 1, "R1", "ieo after reset");
    chk(vec_o, 8'h40, "R4", "vector with nothing pending");
  endtask

  task automatic t_single();
    logic [7:0] v;
    do_set(8'h08);
    chk(irq_o, 1, "R2", "irq after set of source 3");
    chk(vec_o, exp_vec(8'h40, 3), "R4", "vector of source 3");
    do_ack(v);
    chk(v, exp_vec(8'h40, 3), "R4", "ack vector source 3");
    chk(irq_o, 0, "R5", "irq after ack (pending cleared)");
    chk(ieo_o, 0, "R6", "ieo while in service");
    do_reti();
    chk(ieo_o, 1, "R7", "ieo after return");
    chk(irq_o, 0, "R7", "irq after return");
  endtask

  task automatic t_priority();
    logic [7:0] v;
    do_set(8'hFF);
    for (int i = 0; i < 8; i++) begin
      do_ack(v);
      chk(v, exp_vec(8'h40, prio[i]), "R3", $sformatf("rank %0d vector", i));
      do_reti();
    end
    chk(irq_o, 0, "R5", "irq after all acked");
    chk(ieo_o, 1, "R7", "ieo after all returned");
  endtask

  task automatic t_nesting();
    logic [7:0] v;
    do_set(8'h08);
    do_ack(v);
    do_set(8'h01);
    chk(irq_o, 1, "R6", "higher source requests past lower service");
    do_ack(v);
    chk(v, exp_vec(8'h40, 0), "R5", "nested ack vector");
    do_set(8'h08);
    chk(irq_o, 0, "R6", "source blocked by its own service");
    do_reti();
    chk(ieo_o, 0, "R7", "lower still in service after one return");
    chk(irq_o, 0, "R7", "source 3 still blocked");
    do_reti();
    chk(ieo_o, 1, "R7", "all service ended");
    chk(irq_o, 1, "R6", "source 3 unblocked");
    do_ack(v);
    chk(v, exp_vec(8'h40, 3), "R4", "source 3 re-acked");
    do_reti();
  endtask

  task automatic t_clear();
    logic [7:0] v;
    do_set(8'h04);
    do_clr(8'h04);
    chk(irq_o, 0, "R8", "irq after clear");
    chk(vec_o, 8'h40, "R8", "vector after clear");
    do_set(8'h10);
    do_ack(v);
    do_set(8'h10);
    do_clr(8'h10);
    chk(ieo_o, 0, "R8", "in-service kept after clear");
    do_set(8'h01);
    chk(irq_o, 0, "R8", "lower source still masked by kept service");
    do_reti();
    chk(ieo_o, 1, "R8", "return after clear");
    chk(irq_o, 1, "R8", "lower source after return");
    do_ack(v);
    chk(v, exp_vec(8'h40, 0), "R8", "cleared source not chosen");
    do_reti();
  endtask

  task automatic t_daisy();
    logic [7:0] v;
    do_set(8'h80);
    ien_i = 1'b0; #1;
    chk(irq_o, 0, "R9", "irq with ien low");
    chk(ieo_o, 0, "R9", "ieo with ien low");
    ien_i = 1'b1; #1;
    chk(irq_o, 1, "R9", "irq with ien high");
    chk(ieo_o, 1, "R9", "ieo idle");
    @(negedge clk);
    do_ack(v);
    chk(ieo_o, 0, "R9", "ieo with service");
    do_reti();
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    set_i = 8'h20; clr_i = 8'h20; @(negedge clk); set_i = '0; clr_i = '0;
    chk(irq_o, 1, "R10", "set over clear");
    chk(vec_o, exp_vec(8'h40, 5), "R10", "vector after set over clear");
    do_ack(v);
    do_reti();
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    base_vec = 8'hFC;
    do_set(8'h80);
    do_ack(v);
    chk(v, 8'h0A, "R4", "vector wraps");
    do_reti();
    base_vec = 8'h40;
  endtask

  task automatic t_mid_reset();
    logic [7:0] v;
    do_set(8'h0F);
    do_ack(v);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(irq_o, 0, "R1", "irq after mid reset");
    chk(ieo_o, 1, "R1", "ieo after mid reset");
  endtask

  initial begin
    #(2 * CLK_HALF * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_priority();
    t_nesting();
    t_clear();
    t_daisy();
    t_set_wins();
    t_wrap();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule